// File: doc/BRIEF.md
# Synthesizer Loop Core

This block is the digital heart of a phase-locked frequency synthesizer. A reference counter divides the reference clock by a ratio picked from a fixed five-entry table by a 3-bit mode code, giving the comparison rate. A 15-bit programmable counter divides the prescaled RF edge stream, supplied as a one-cycle enable `fb_tick`, to give the loop feedback rate. A phase-frequency detector turns the arrival order of the two rates into `up` and `dn` pulses for an external charge pump.

A lock monitor watches the width of those pulses. After enough clean comparison periods in a row it declares lock. It then releases the lock pad by dropping its output enable, and it switches the charge-pump current select from the high setting (150 units) to the low setting (50 units), which reduces short-term jitter. Writing a new divisor restarts the loop: the lock is dropped, the current select goes back to high and the detector is cleared.

All logic runs on the reference clock `clk`. It uses a synchronous active-high reset. Every output comes from a register.

Top module: `synth_loop_core`

## Requirements
- R1: The reference period in `clk` cycles is set by `mode`: code 4 gives 512, code 3 gives 1280, code 2 gives 1024, code 1 gives 2048 and code 0 gives 640, each shifted right by `RATIO_SHIFT`. With a 4 MHz reference and code 4, this gives 7.8125 kHz.
- R2: Mode codes 5, 6 and 7 give the same ratio as code 0.
- R3: On `load`, the divisor is taken from `div_word`. When `word_wide`=1 all 15 bits are used. When `word_wide`=0, bit 14 is forced to 0 and bits 13:0 are used. The feedback counter then gives one feedback pulse per N `fb_tick` enables, where N is the divisor. A divisor of 0 or 1 gives a pulse on every enable.
- R4: `up` rises in the cycle after a reference period ends, and `dn` rises in the cycle after a feedback pulse. Once both are high, both fall at the next edge.
- R5: `up` and `dn` are never both high for two cycles in a row unless both events occur again.
- R6: Lock is set at the end of the `LOCK_CYCLES`-th consecutive reference period in which no run of `up` or `dn` activity lasted more than `PULSE_MAX` cycles. Periods are counted from reset or from the last load.
- R7: Lock is lost in the cycle after any activity run first exceeds `PULSE_MAX` cycles.
- R8: A `load` clears lock, sets `cp_high`, and clears `up` and `dn` at the next edge.
- R9: Out of lock, `cp_high`=1 (150-unit current) and `flag_oe`=1 (lock pad driven low). In lock, `cp_high`=0 (50-unit current) and `flag_oe`=0 (lock pad high-impedance).
- R10: After reset, `up`=0, `dn`=0, `cp_high`=1 and `flag_oe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Reference ratio select |
| fb_tick | input | 1 | One-cycle enable per prescaled RF edge |
| div_word | input | 15 | Divisor word |
| word_wide | input | 1 | 1: 15-bit entry, 0: 14-bit entry |
| load | input | 1 | Divisor load strobe |
| up | output | 1 | Pump-up pulse |
| dn | output | 1 | Pump-down pulse |
| cp_high | output | 1 | Charge-pump current select, 1 = high |
| flag_oe | output | 1 | Lock pad drive enable, 1 = driven low |

## Verification
The bench builds the core with `RATIO_SHIFT`=4, `PULSE_MAX`=4 and `LOCK_CYCLES`=16. This shrinks the reference periods to 32 to 128 cycles, so all eight mode codes can be swept and several full lock episodes fit in a short run. The bench aligns each divisor load to a visible `up` edge, so the exact lock edge, the loss edge after the feedback stops, and the shape of the pulses follow by arithmetic. The 14-bit and 15-bit entries are told apart with a word whose bit 14 decides whether the loop can lock. A half-rate `fb_tick` stream shows that the counter counts enables, not clocks.

// File: rtl/slc_pkg.sv
package slc_pkg;
  localparam int MAX_RATIO = 2048;

  // Reference ratio per mode code; unused codes fall back to code 0.
  function automatic int ref_ratio(input logic [2:0] code);
    case (code)
      3'd4:    ref_ratio = 512;
      3'd3:    ref_ratio = 1280;
      3'd2:    ref_ratio = 1024;
      3'd1:    ref_ratio = 2048;
      default: ref_ratio = 640;
    endcase
  endfunction
endpackage

// File: rtl/slc_ref_div.sv
module slc_ref_div #(
  parameter int RATIO_SHIFT = 0,
  parameter int CW = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  output logic       cmp_tick
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  always_comb begin
    lim = CW'((slc_pkg::ref_ratio(mode) >> RATIO_SHIFT) - 1);
    cmp_tick = (cnt_q >= lim);
  end

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (cmp_tick) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  AST_REF_WRAP: assert property (@(posedge clk) disable iff (rst)
    cmp_tick |=> (cnt_q == '0)); // R1
endmodule

// File: rtl/slc_fb_div.sv
module slc_fb_div #(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fb_tick,
  input  logic [DIV_W-1:0] div_word,
  input  logic             word_wide,
  input  logic             load,
  output logic             fb_pulse
);
  localparam int NARROW_W = DIV_W - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   cnt_next;

  always_comb begin
    cnt_next = {1'b0, cnt_q} + 1'b1;
    fb_pulse = fb_tick && !load && (cnt_next >= {1'b0, div_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      div_q <= word_wide ? div_word : {1'b0, div_word[NARROW_W-1:0]};
      cnt_q <= '0;
    end else if (fb_tick) begin
      cnt_q <= fb_pulse ? '0 : cnt_next[DIV_W-1:0];
    end
  end

  AST_FB_RESTART: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == '0)); // R3
  AST_FB_NARROW: assert property (@(posedge clk) disable iff (rst)
    (load && !word_wide) |=> !div_q[DIV_W-1]); // R3
endmodule

// File: rtl/slc_pfd.sv
module slc_pfd (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic cmp_tick,
  input  logic fb_pulse,
  output logic up_q,
  output logic dn_q
);
  logic both;

  always_comb both = up_q & dn_q;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= (up_q & ~both) | cmp_tick;
      dn_q <= (dn_q & ~both) | fb_pulse;
    end
  end

  AST_UP_SET: assert property (@(posedge clk) disable iff (rst)
    (cmp_tick && !load) |=> up_q); // R4
  AST_DN_SET: assert property (@(posedge clk) disable iff (rst)
    (fb_pulse && !load) |=> dn_q); // R4
  AST_PAIR_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (up_q && dn_q && !cmp_tick && !fb_pulse) |=> (!up_q && !dn_q)); // R5
endmodule

// File: rtl/slc_lock_det.sv
module slc_lock_det #(
  parameter int LOCK_CYCLES = 16,
  parameter int PULSE_MAX = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic cmp_tick,
  input  logic up,
  input  logic dn,
  output logic locked_q,
  output logic cp_high_q
);
  localparam int GOOD_W = $clog2(LOCK_CYCLES + 1);
  localparam int RUN_W  = $clog2(PULSE_MAX + 1);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_CYCLES - 1);
  localparam logic [GOOD_W-1:0] GOOD_SAT  = GOOD_W'(LOCK_CYCLES);
  localparam logic [RUN_W-1:0]  RUN_LIM   = RUN_W'(PULSE_MAX);

  logic [GOOD_W-1:0] good_q;
  logic [RUN_W-1:0]  run_q;
  logic              bad_q;
  logic              active;
  logic              viol;
  logic              lock_nx;

  always_comb begin
    active = up | dn;
    viol   = active && (run_q == RUN_LIM);
    if (viol)
      lock_nx = 1'b0;
    else if (cmp_tick && !bad_q && good_q >= GOOD_LAST)
      lock_nx = 1'b1;
    else
      lock_nx = locked_q;
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      run_q     <= '0;
      good_q    <= '0;
      bad_q     <= 1'b0;
      locked_q  <= 1'b0;
      cp_high_q <= 1'b1;
    end else begin
      if (!active)     run_q <= '0;
      else if (!viol)  run_q <= run_q + 1'b1;
      if (cmp_tick) begin
        bad_q <= 1'b0;
        if (bad_q || viol)         good_q <= '0;
        else if (good_q != GOOD_SAT) good_q <= good_q + 1'b1;
      end else if (viol) begin
        bad_q <= 1'b1;
      end
      locked_q  <= lock_nx;
      cp_high_q <= ~lock_nx;
    end
  end

  AST_LOCK_AT_PERIOD: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_q) |-> $past(cmp_tick)); // R6
  AST_LOSS_ON_WIDE: assert property (@(posedge clk) disable iff (rst)
    viol |=> (!locked_q && cp_high_q)); // R7
  AST_LOAD_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    load |=> (!locked_q && cp_high_q)); // R8
endmodule

// File: rtl/synth_loop_core.sv
module synth_loop_core #(
  parameter int DIV_W = 15,
  parameter int RATIO_SHIFT = 0,
  parameter int LOCK_CYCLES = 16,
  parameter int PULSE_MAX = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode,
  input  logic             fb_tick,
  input  logic [DIV_W-1:0] div_word,
  input  logic             word_wide,
  input  logic             load,
  output logic             up,
  output logic             dn,
  output logic             cp_high,
  output logic             flag_oe
);
  localparam int REF_CW = $clog2(slc_pkg::MAX_RATIO);

  logic cmp_tick;
  logic fb_pulse;
  logic up_q;
  logic dn_q;
  logic locked_q;
  logic cp_high_q;

  slc_ref_div #(.RATIO_SHIFT(RATIO_SHIFT), .CW(REF_CW)) u_ref (
    .clk(clk), .rst(rst), .mode(mode), .cmp_tick(cmp_tick));

  slc_fb_div #(.DIV_W(DIV_W)) u_fb (
    .clk(clk), .rst(rst), .fb_tick(fb_tick), .div_word(div_word),
    .word_wide(word_wide), .load(load), .fb_pulse(fb_pulse));

  slc_pfd u_pfd (
    .clk(clk), .rst(rst), .load(load), .cmp_tick(cmp_tick),
    .fb_pulse(fb_pulse), .up_q(up_q), .dn_q(dn_q));

  slc_lock_det #(.LOCK_CYCLES(LOCK_CYCLES), .PULSE_MAX(PULSE_MAX)) u_lock (
    .clk(clk), .rst(rst), .load(load), .cmp_tick(cmp_tick),
    .up(up_q), .dn(dn_q), .locked_q(locked_q), .cp_high_q(cp_high_q));

  always_comb begin
    up      = up_q;
    dn      = dn_q;
    cp_high = cp_high_q;
    flag_oe = ~locked_q;
  end

  AST_PAD_MATCHES_PUMP: assert property (@(posedge clk) disable iff (rst)
    flag_oe == cp_high); // R9
endmodule

// File: tb/synth_loop_core_bench.sv
module synth_loop_core_bench;
  localparam int SHIFT = 4;
  localparam int PMAX  = 4;
  localparam int LCYC  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] mode = 3'd4;
  logic fb_tick = 1'b1;
  logic [14:0] word = '0;
  logic wide = 1'b0;
  logic load = 1'b0;
  logic up, dn, cp_high, flag_oe;
  int fb_pat = 1;
  int n_chk = 0;
  int n_bad = 0;
  logic half = 1'b0;

  always #10 clk = ~clk;

  synth_loop_core #(.DIV_W(15), .RATIO_SHIFT(SHIFT), .LOCK_CYCLES(LCYC),
                    .PULSE_MAX(PMAX)) u_synth_loop_core (
    .clk(clk), .rst(rst), .mode(mode), .fb_tick(fb_tick), .div_word(word),
    .word_wide(wide), .load(load), .up(up), .dn(dn), .cp_high(cp_high),
    .flag_oe(flag_oe));

  initial forever begin
    @(negedge clk);
    #1;
    half = ~half;
    case (fb_pat)
      0:       fb_tick = 1'b0;
      2:       fb_tick = half;
      default: fb_tick = 1'b1;
    endcase
  end

  function automatic int ratio(input int m);
    case (m)
      4: ratio = 512 >> SHIFT;
      3: ratio = 1280 >> SHIFT;
      2: ratio = 1024 >> SHIFT;
      1: ratio = 2048 >> SHIFT;
      default: ratio = 640 >> SHIFT;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic load_word(input int w, input bit wd);
    word = 15'(w);
    wide = wd;
    load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_up_rise();
    logic prev;
    prev = up;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (up && !prev) return;
      prev = up;
    end
    chk(1'b0, "timeout waiting for up", 0, 1);
  endtask

  // Align a load to an up edge; with N equal to the period the lock edge is exact.
  task automatic align_load(input int w, input bit wd, input int r);
    load_word(1, 1'b1);
    repeat (3 * r) @(negedge clk);
    wait_up_rise();
    word = 15'(w);
    wide = wd;
    load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic exact_lock(input int r, input string req);
    repeat (LCYC * r - 2) @(posedge clk);
    @(negedge clk);
    chk(flag_oe == 1'b1 && cp_high == 1'b1, req, int'(flag_oe), 1);
    @(posedge clk);
    @(negedge clk);
    chk(flag_oe == 1'b0, req, int'(flag_oe), 0);
    chk(cp_high == 1'b0, "R9 low current in lock", int'(cp_high), 0);
  endtask

  initial begin
    int r;
    int cnt;
    repeat (4) @(negedge clk);
    chk(up == 1'b0 && dn == 1'b0, "R10 pulses idle in reset", int'(up) + int'(dn), 0);
    chk(cp_high == 1'b1, "R10 high current after reset", int'(cp_high), 1);
    chk(flag_oe == 1'b1, "R10 pad driven after reset", int'(flag_oe), 1);
    rst = 1'b0;
    load_word(1, 1'b1);

    // R1 and R2: period of up for every mode code.
    for (int m = 0; m < 8; m++) begin
      mode = 3'(m);
      wait_up_rise();
      wait_up_rise();
      cnt = 0;
      begin
        logic prev;
        prev = up;
        for (int i = 0; i < 4000; i++) begin
          @(negedge clk);
          cnt++;
          if (up && !prev) break;
          prev = up;
        end
      end
      if (m >= 5) chk(cnt == ratio(m), "R2 spare code acts as code 0", cnt, ratio(0));
      else        chk(cnt == ratio(m), "R1 reference period", cnt, ratio(m));
    end

    // R6, R9: exact lock with N equal to the period in mode 4.
    mode = 3'd4;
    r = ratio(4);
    align_load(r, 1'b1, r);
    exact_lock(r, "R6 lock edge");

    // R4, R5: shape of the pulses while locked.
    wait_up_rise();
    chk(dn == 1'b0, "R4 dn follows up by one cycle", int'(dn), 0);
    @(negedge clk);
    chk(up && dn, "R4 both high one cycle", int'(up) + int'(dn), 2);
    @(negedge clk);
    chk(!up && !dn, "R5 pair released", int'(up) + int'(dn), 0);

    // R7: stop feedback; lock drops after PMAX+1 cycles of up.
    fb_pat = 0;
    wait_up_rise();
    repeat (PMAX) @(posedge clk);
    @(negedge clk);
    chk(flag_oe == 1'b0, "R7 lock held up to the limit", int'(flag_oe), 0);
    @(posedge clk);
    @(negedge clk);
    chk(flag_oe == 1'b1, "R7 lock lost past the limit", int'(flag_oe), 1);
    chk(cp_high == 1'b1, "R7 high current after loss", int'(cp_high), 1);

    // R8: relock, then a load clears everything.
    fb_pat = 1;
    align_load(r, 1'b1, r);
    exact_lock(r, "R6 relock edge");
    wait_up_rise();
    load_word(r, 1'b1);
    chk(flag_oe == 1'b1 && cp_high == 1'b1, "R8 load drops lock", int'(cp_high), 1);
    chk(!up && !dn, "R8 load clears pulses", int'(up) + int'(dn), 0);

    // R3: 14-bit entry ignores bit 14, 15-bit entry keeps it.
    align_load(16'h4000 | r, 1'b0, r);
    exact_lock(r, "R3 narrow entry locks");
    align_load(16'h4000 | r, 1'b1, r);
    repeat (40 * r) @(negedge clk);
    chk(flag_oe == 1'b1, "R3 wide entry keeps bit 14", int'(flag_oe), 1);

    // R3: enables counted, not clocks (half-rate feedback).
    fb_pat = 2;
    align_load(r / 2, 1'b1, r);
    repeat (20 * r) @(negedge clk);
    chk(flag_oe == 1'b0, "R3 half-rate ticks lock", int'(flag_oe), 0);
    chk(cp_high == 1'b0, "R9 low current half-rate", int'(cp_high), 0);

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end
endmodule